// File: doc/BRIEF.md
# SPI Slave Byte Interface with Buffered Receive

This block is the device side of a four-wire serial link. An external master drives the serial clock, the data line toward the block and an active-low select. The block returns data on its own output line. Each select window carries one 8-bit transfer, sent most significant bit first, over 16 serial clock edges. Both idle clock levels are supported, and so are both data phases. Each is chosen by a static input.

All serial inputs are oversampled by the faster system clock through synchronizer chains, and edges are classified in that domain. An incoming bit is first caught in a sample flop on its latching edge. It enters the receive shift register on the next shifting edge. When the 16th edge arrives, the assembled byte is copied into a parallel receive register. A single-cycle valid strobe marks that update. The byte to transmit is captured when select is first seen low, and later changes to the transmit input have no effect on the transfer in progress.

Top module: `spi_slv_core`

## Requirements
- R1: After reset, rx_data is 0, and rx_valid and miso_oe are low.
- R2: A complete 16-edge transfer places the 8 bits presented on mosi into rx_data, with the first bit at bit 7. This holds for all four combinations of cpol and cpha.
- R3: During a complete transfer, the master reads the captured transmit byte on miso, bit 7 first. This holds for all four combinations of cpol and cpha.
- R4: With cpha=0, bit 7 of the transmit byte is on miso once select is seen low, before the first clock edge.
- R5: With cpha=1, miso reads 0 after select falls and until the first clock edge. That first edge drives bit 7.
- R6: rx_data keeps its previous value throughout a transfer and changes only when the last bit completes.
- R7: Every complete transfer produces exactly one rx_valid pulse, one system clock long, together with the rx_data update.
- R8: If select rises before the 16th edge, the transfer is aborted: no rx_valid pulse, and rx_data is unchanged.
- R9: miso_oe is high only while the synchronized select is low, and miso is 0 whenever miso_oe is low.
- R10: tx_data is sampled once, when select falls. Changes to tx_data later in the same select window do not alter the bits sent.
- R11: Clock edges beyond the 16th in one select window are ignored. They produce no second pulse and do not change rx_data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpol | input | 1 | Serial clock idle level (0 = low, 1 = high) |
| cpha | input | 1 | Data phase (0 = latch on odd edges, 1 = latch on even edges) |
| sck | input | 1 | Serial clock from the master |
| mosi | input | 1 | Serial data from the master |
| ss_n | input | 1 | Active-low select from the master |
| tx_data | input | 8 | Byte to send, sampled when select falls |
| miso | output | 1 | Serial data to the master, 0 while not enabled |
| miso_oe | output | 1 | Output enable for miso |
| rx_data | output | 8 | Last completely received byte |
| rx_valid | output | 1 | One-cycle strobe on each rx_data update |

## Verification
The bound checker watches several things on every cycle: rx_data changes only together with rx_valid, the strobe never lasts two cycles, no strobe occurs with the output disabled, miso is quiet while disabled, and the first miso value after select falls is correct in each phase. The following can only be shown by the bench's serial master model: the bit order in both directions across the four clock modes, that aborts leave the register untouched, that surplus edges are ignored, and that a late change to the transmit byte is ignored.

// File: rtl/spi_slv_pkg.sv
package spi_slv_pkg;

   // classification of one detected serial clock transition
   typedef enum logic [1:0] {
      EDGE_NONE  = 2'd0,
      EDGE_LATCH = 2'd1,
      EDGE_SHIFT = 2'd2
   } edge_kind_e;

   // edge number parity vs. phase: leading edges are odd-numbered
   function automatic edge_kind_e classify_edge(input logic leading, input logic phase);
      return (leading ^ phase) ? EDGE_LATCH : EDGE_SHIFT;
   endfunction

endpackage

// File: rtl/spi_slv_sync.sv
module spi_slv_sync #(
   parameter int          WIDTH   = 1,
   parameter int          STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);

   initial begin
      if (STAGES < 2) $error("spi_slv_sync: STAGES must be at least 2");
      if (WIDTH < 1)  $error("spi_slv_sync: WIDTH must be at least 1");
   end

   genvar b;
   generate
      for (b = 0; b < WIDTH; b++) begin : g_bit
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= {STAGES{RST_VAL[b]}};
            else        chain <= {chain[STAGES-2:0], d_async[b]};
         end
         assign q_sync[b] = chain[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/spi_slv_edge.sv
module spi_slv_edge
   import spi_slv_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sck_s,
   input  logic       cpol,
   input  logic       cpha,
   output edge_kind_e kind
);

   logic sck_prev;
   logic toggled;
   logic leading;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_prev <= 1'b0;
      else        sck_prev <= sck_s;
   end

   assign toggled = sck_s ^ sck_prev;
   // a leading edge moves the clock away from its idle level
   assign leading = sck_s ^ cpol;

   always_comb begin
      kind = EDGE_NONE;
      if (toggled) kind = classify_edge(leading, cpha);
   end

endmodule

// File: rtl/spi_slv_datapath.sv
module spi_slv_datapath
   import spi_slv_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpha,
   input  logic              mosi_s,
   input  logic              ss_s,
   input  edge_kind_e        kind,
   input  logic [DATA_W-1:0] tx_data,
   output logic              miso,
   output logic              miso_oe,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_valid
);

   localparam int EDGES  = 2 * DATA_W;
   localparam int CNT_W  = $clog2(EDGES + 1);
   localparam logic [CNT_W-1:0] LAST_EDGE = CNT_W'(EDGES - 1);

   logic              ss_prev;
   logic              ss_fall;
   logic              ss_rise;
   logic              busy;
   logic              sample_q;
   logic [CNT_W-1:0]  edge_cnt;
   logic [DATA_W-1:0] tx_sh;
   logic [DATA_W-1:0] tx_hold;
   logic [DATA_W-2:0] rx_sh;
   logic              final_bit;

   assign ss_fall   = ss_prev & ~ss_s;
   assign ss_rise   = ~ss_prev & ss_s;
   // phase 1 ends on a latching edge, so the last bit bypasses the sample flop
   assign final_bit = cpha ? mosi_s : sample_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ss_prev  <= 1'b1;
         busy     <= 1'b0;
         miso_oe  <= 1'b0;
         sample_q <= 1'b0;
         edge_cnt <= '0;
         tx_sh    <= '0;
         tx_hold  <= '0;
         rx_sh    <= '0;
         rx_data  <= '0;
         rx_valid <= 1'b0;
      end else begin
         ss_prev  <= ss_s;
         rx_valid <= 1'b0;
         if (ss_fall) begin
            busy     <= 1'b1;
            miso_oe  <= 1'b1;
            edge_cnt <= '0;
            tx_hold  <= tx_data;
            tx_sh    <= cpha ? '0 : tx_data;
            rx_sh    <= '0;
         end else if (ss_rise) begin
            busy    <= 1'b0;
            miso_oe <= 1'b0;
         end else if (busy && kind != EDGE_NONE) begin
            edge_cnt <= edge_cnt + 1'b1;
            if (edge_cnt == LAST_EDGE) begin
               busy     <= 1'b0;
               rx_data  <= {rx_sh, final_bit};
               rx_valid <= 1'b1;
            end else if (kind == EDGE_LATCH) begin
               sample_q <= mosi_s;
            end else if (cpha && edge_cnt == '0) begin
               tx_sh <= tx_hold;
            end else begin
               tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
               rx_sh <= {rx_sh[DATA_W-3:0], sample_q};
            end
         end
      end
   end

   assign miso = miso_oe & tx_sh[DATA_W-1];

endmodule

// File: rtl/spi_slv_core.sv
module spi_slv_core
   import spi_slv_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpol,
   input  logic              cpha,
   input  logic              sck,
   input  logic              mosi,
   input  logic              ss_n,
   input  logic [DATA_W-1:0] tx_data,
   output logic              miso,
   output logic              miso_oe,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_valid
);

   localparam int PINS = 3;

   initial begin
      if (DATA_W < 3)      $error("spi_slv_core: DATA_W must be at least 3");
      if (SYNC_STAGES < 2) $error("spi_slv_core: SYNC_STAGES must be at least 2");
   end

   logic [PINS-1:0] pins_s;
   logic            sck_s;
   logic            mosi_s;
   logic            ss_s;
   edge_kind_e      kind;

   spi_slv_sync #(
      .WIDTH   (PINS),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (3'b100)
   ) i_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async ({ss_n, mosi, sck}),
      .q_sync  (pins_s)
   );

   assign sck_s  = pins_s[0];
   assign mosi_s = pins_s[1];
   assign ss_s   = pins_s[2];

   spi_slv_edge i_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .sck_s (sck_s),
      .cpol  (cpol),
      .cpha  (cpha),
      .kind  (kind)
   );

   spi_slv_datapath #(
      .DATA_W (DATA_W)
   ) i_dp (
      .clk      (clk),
      .rst_n    (rst_n),
      .cpha     (cpha),
      .mosi_s   (mosi_s),
      .ss_s     (ss_s),
      .kind     (kind),
      .tx_data  (tx_data),
      .miso     (miso),
      .miso_oe  (miso_oe),
      .rx_data  (rx_data),
      .rx_valid (rx_valid)
   );

endmodule

// File: rtl/spi_slv_chk.sv
module spi_slv_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpha,
   input logic [DATA_W-1:0] tx_data,
   input logic              miso,
   input logic              miso_oe,
   input logic [DATA_W-1:0] rx_data,
   input logic              rx_valid
);

   // R6
   rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_data != $past(rx_data)) |-> rx_valid);

   // R7
   strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

   // R8
   strobe_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> miso_oe);

   // R9
   quiet_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !miso_oe |-> !miso);

   // R4
   first_bit_phase0_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(miso_oe) && !cpha) |-> (miso == $past(tx_data[DATA_W-1])));

   // R5
   first_bit_phase1_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(miso_oe) && cpha) |-> !miso);

endmodule

bind spi_slv_core spi_slv_chk #(.DATA_W(DATA_W)) i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cpha     (cpha),
   .tx_data  (tx_data),
   .miso     (miso),
   .miso_oe  (miso_oe),
   .rx_data  (rx_data),
   .rx_valid (rx_valid)
);

// File: tb/test_spi_slv_core.sv
module test_spi_slv_core;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cpol = 1'b0;
   logic       cpha = 1'b0;
   logic       sck = 1'b0;
   logic       mosi = 1'b0;
   logic       ss_n = 1'b1;
   logic [7:0] tx_data = 8'h00;
   logic       miso;
   logic       miso_oe;
   logic [7:0] rx_data;
   logic       rx_valid;

   int checks = 0;
   int errors = 0;
   int pulses = 0;
   logic [7:0] last_rx = 8'h00;
   logic [7:0] held_rx = 8'h00;

   always #10 clk = ~clk;

   spi_slv_core i_spi_slv_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .cpol     (cpol),
      .cpha     (cpha),
      .sck      (sck),
      .mosi     (mosi),
      .ss_n     (ss_n),
      .tx_data  (tx_data),
      .miso     (miso),
      .miso_oe  (miso_oe),
      .rx_data  (rx_data),
      .rx_valid (rx_valid)
   );

   always @(negedge clk) begin
      if (rx_valid) begin
         pulses  <= pulses + 1;
         last_rx <= rx_data;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic int exp_pulses(input int nedges);
      return (nedges >= 16) ? 1 : 0;
   endfunction

   function automatic bit is_latch(input bit ph, input int k);
      return ph ? (k % 2 == 0) : (k % 2 == 1);
   endfunction

   function automatic int bit_of_edge(input int k);
      return 7 - (k - 1) / 2;
   endfunction

   task automatic xfer(input bit pol, input bit ph, input logic [7:0] mtx,
                       input logic [7:0] stx, input int nedges, input int half);
      logic [7:0] mrx = 8'h00;
      @(negedge clk);
      cpol = pol; cpha = ph; sck = pol;
      repeat (4) @(negedge clk);
      pulses  = 0;
      tx_data = stx;
      mosi    = ph ? 1'b0 : mtx[7];
      ss_n    = 1'b0;
      repeat (5) @(negedge clk);
      tx_data = ~stx;                          // R10: late change must be ignored
      @(negedge clk);
      check("R9 oe in window", {31'd0, miso_oe}, 32'd1);
      if (!ph) check("R4 first bit before edge", {31'd0, miso}, {31'd0, stx[7]});
      else     check("R5 miso low before edge", {31'd0, miso}, 32'd0);
      for (int k = 1; k <= nedges; k++) begin
         if (is_latch(ph, k) && k <= 16) mrx[bit_of_edge(k)] = miso;
         sck = ~sck;
         if (!is_latch(ph, k) && k < 16) begin
            if (ph) mosi = mtx[bit_of_edge(k)];
            else    mosi = mtx[7 - k / 2];
         end
         repeat (half) @(negedge clk);
         if (k == 8) check("R6 rx_data held mid transfer", {24'd0, rx_data}, {24'd0, held_rx});
      end
      repeat (4) @(negedge clk);
      ss_n = 1'b1;
      repeat (5) @(negedge clk);
      check("R9 oe off after select", {30'd0, miso_oe, miso}, 32'd0);
      check(nedges > 16 ? "R7 R11 pulse count" : "R7 R8 pulse count", pulses, exp_pulses(nedges));
      if (nedges >= 16) begin
         held_rx = mtx;
         check(nedges > 16 ? "R2 R11 received byte" : "R2 received byte", {24'd0, last_rx}, {24'd0, mtx});
         check("R3 R10 transmitted byte", {24'd0, mrx}, {24'd0, stx});
      end
      check("R6 R8 rx_data after window", {24'd0, rx_data}, {24'd0, held_rx});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      check("R1 reset rx_data", {24'd0, rx_data}, 32'd0);
      check("R1 reset strobes", {30'd0, rx_valid, miso_oe}, 32'd0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      // directed: all four modes
      xfer(1'b0, 1'b0, 8'hA5, 8'h3C, 16, 5);
      xfer(1'b1, 1'b0, 8'h5A, 8'hC3, 16, 5);
      xfer(1'b0, 1'b1, 8'hFF, 8'h81, 16, 4);
      xfer(1'b1, 1'b1, 8'h01, 8'hFE, 16, 4);
      // abort (R8) and surplus edges (R11)
      xfer(1'b0, 1'b0, 8'h77, 8'h11, 9, 5);
      xfer(1'b1, 1'b1, 8'h00, 8'h80, 15, 5);
      xfer(1'b0, 1'b1, 8'h96, 8'h69, 18, 5);
      xfer(1'b1, 1'b0, 8'h00, 8'hFF, 20, 5);
      // random mix
      for (int n = 0; n < 40; n++) begin
         int ne;
         ne = ($urandom % 5 == 0) ? (1 + $urandom % 15) : 16;
         xfer(1'($urandom), 1'($urandom), 8'($urandom), 8'($urandom), ne, 4 + $urandom % 5);
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule